// File: doc/BRIEF.md
# Segmented Data Address Extender

This block sits between a small 8-bit CPU and its data memories. Every data access carries an 8-bit address. The block turns that address into a 16-bit physical address. Addresses with the top bit set always land in a fixed upper base page. Addresses with the top bit clear are moved into one of 256 segments of 128 bytes, chosen by an 8-bit segment register. The one exception is an access made through the stack pointer: its lower-half addresses always go to segment 0.

The block owns two memory-mapped control registers: the segment register at 8-bit address 0xFF and the stack pointer at 0xFD. It also reports which physical RAM bank backs each address. When no RAM backs an address, the block supplies the read data itself. The RAM arrays, the CPU datapath and any pointer arithmetic live outside the block. The address and bank outputs are combinational from the access inputs and the held registers. Register writes land on the next clock edge.

Top module: `seg_addr_xlate`

## Requirements
- R1: When acc_addr[7] is 1, phys_addr equals {8'h00, acc_addr}, whatever the segment register holds and whether or not acc_stack is set.
- R2: When acc_addr[7] is 0 and acc_stack is 0, phys_addr equals {seg_q, 1'b0, acc_addr[6:0]}.
- R3: When acc_addr[7] is 0 and acc_stack is 1, phys_addr equals {8'h00, 1'b0, acc_addr[6:0]}. A stack write never changes the segment register, even when it is addressed at 0xFF.
- R4: After reset, seg_q is 0x00 and sp_q is 0x6F.
- R5: The bank output is 0 (none), 1 (low RAM, physical 0x0000–0x006F), 2 (general registers, physical 0x00F0–0x00FE except 0x00FD), 3 (extension RAM, physical 0x0100–0x017F) or 4 (in-block control register, physical 0x00FD or 0x00FF). Every other physical address gives 0, including 0x0070–0x00EF and every segment other than 0 and 1.
- R6: A read at bank 0 raises local_rd and returns local_data = 0xFF. A write at bank 0 leaves ram_we low and changes no register.
- R7: A non-stack write to 8-bit address 0xFF loads acc_wdata into seg_q at the next clock edge. The access in the write cycle still uses the old segment value, and the access in the following cycle uses the new one.
- R8: A write to 8-bit address 0xFD loads acc_wdata into sp_q at the next edge. This holds for stack and non-stack accesses. A read at bank 4 raises local_rd and returns sp_q for 0x00FD or seg_q for 0x00FF.
- R9: ram_we is high exactly when acc_valid and acc_wr are high and bank is 1, 2 or 3. While acc_valid is low, ram_we and local_rd stay low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A data access is made this cycle |
| acc_wr | input | 1 | Access is a write (0 = read) |
| acc_stack | input | 1 | Access goes through the stack pointer |
| acc_addr | input | 8 | 8-bit CPU data address |
| acc_wdata | input | 8 | Write data |
| phys_addr | output | 16 | Translated physical address |
| bank | output | 3 | Backing bank code (see R5) |
| ram_we | output | 1 | Write strobe for the selected RAM bank |
| local_rd | output | 1 | The block supplies the read data |
| local_data | output | 8 | Read data for bank 0 (fill) or bank 4 (register) |
| seg_q | output | 8 | Current segment register |
| sp_q | output | 8 | Current stack pointer |

## Verification
Directed sweeps run every address through the upper half with non-zero segments, to show that the top bit alone keeps the segment value out of upper-half addresses. The lower half is then run with segments 0, 1 and an unpopulated value, which separates low RAM, extension RAM and fill behaviour. Stack accesses are mixed with a non-zero segment, including stack writes to 0xFF, to show that segment bypass and write protection are separate from ordinary accesses. Back-to-back segment writes followed by reads check that a new segment value applies from the next cycle and not from the write cycle. A long random stream with writes to the control addresses weighted upward is then compared every cycle against a behavioural model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SW = 8;
  localparam int PW = SW + AW;
  localparam int BW = 3;
  localparam logic [AW-1:0] SEG_REG_ADR = 8'hFF;
  localparam logic [AW-1:0] SP_REG_ADR  = 8'hFD;
  localparam logic [AW-1:0] LOW_RAM_LAST = 8'h6F;
  localparam logic [AW-1:0] GREG_FIRST  = 8'hF0;

  typedef enum logic [BW-1:0] {
    BK_NONE = 3'd0,
    BK_LOW  = 3'd1,
    BK_GREG = 3'd2,
    BK_EXT  = 3'd3,
    BK_CTL  = 3'd4
  } bank_t;

  // Form the physical address for one access.
  function automatic logic [PW-1:0] xlate(input logic [AW-1:0] a,
                                          input logic [SW-1:0] seg,
                                          input logic stk);
    logic [SW-1:0] hi;
    if (a[AW-1]) hi = '0;
    else if (stk) hi = '0;
    else hi = seg;
    return {hi, (a[AW-1] ? a : {1'b0, a[AW-2:0]})};
  endfunction

  // Decide which storage backs a physical address.
  function automatic bank_t decode(input logic [PW-1:0] p,
                                   input logic [SW-1:0] ext_seg);
    logic [SW-1:0] hi;
    logic [AW-1:0] lo;
    hi = p[PW-1:AW];
    lo = p[AW-1:0];
    if (hi == '0) begin
      if (lo <= LOW_RAM_LAST) return BK_LOW;
      if (lo == SEG_REG_ADR || lo == SP_REG_ADR) return BK_CTL;
      if (lo >= GREG_FIRST) return BK_GREG;
      return BK_NONE;
    end
    if (hi == ext_seg && !lo[AW-1]) return BK_EXT;
    return BK_NONE;
  endfunction
endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
  import seg_xlate_pkg::*;
#(
  parameter logic [DW-1:0] SP_INIT  = 8'h6F,
  parameter logic [SW-1:0] SEG_INIT = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_seg,
  input  logic          ld_sp,
  input  logic [DW-1:0] wdata,
  output logic [SW-1:0] seg,
  output logic [DW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_INIT;
      sp  <= SP_INIT;
    end else begin
      if (ld_seg) seg <= wdata[SW-1:0];
      if (ld_sp)  sp  <= wdata;
    end
  end
endmodule

// File: rtl/seg_xlate_map.sv
module seg_xlate_map
  import seg_xlate_pkg::*;
#(
  parameter logic [SW-1:0] EXT_SEGMENT = 8'h01
) (
  input  logic [AW-1:0] addr,
  input  logic          stk,
  input  logic [SW-1:0] seg,
  output logic [PW-1:0] phys,
  output bank_t         bank
);
  always_comb begin
    phys = xlate(addr, seg, stk);
    bank = decode(phys, EXT_SEGMENT);
  end
endmodule

// File: rtl/seg_xlate_rdmux.sv
module seg_xlate_rdmux
  import seg_xlate_pkg::*;
#(
  parameter logic [DW-1:0] FILL = 8'hFF
) (
  input  bank_t         bank,
  input  logic [AW-1:0] lo,
  input  logic [SW-1:0] seg,
  input  logic [DW-1:0] sp,
  output logic [DW-1:0] data
);
  always_comb begin
    data = FILL;
    if (bank == BK_CTL) begin
      if (lo == SEG_REG_ADR) data = DW'(seg);
      else data = sp;
    end
  end
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
  import seg_xlate_pkg::*;
#(
  parameter logic [DW-1:0] SP_INIT     = 8'h6F,
  parameter logic [SW-1:0] EXT_SEGMENT = 8'h01,
  parameter logic [DW-1:0] FILL        = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_wr,
  input  logic          acc_stack,
  input  logic [7:0]    acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic [15:0]   phys_addr,
  output logic [2:0]    bank,
  output logic          ram_we,
  output logic          local_rd,
  output logic [7:0]    local_data,
  output logic [7:0]    seg_q,
  output logic [7:0]    sp_q
);
  bank_t         bank_w;
  logic [PW-1:0] phys_w;
  logic          wr_ev;
  logic          rd_ev;
  logic          seg_hit;
  logic          sp_hit;
  logic          seg_ld_ev;
  logic          sp_ld_ev;
  logic          ram_bank;

  seg_xlate_map #(.EXT_SEGMENT(EXT_SEGMENT)) u_map (
    .addr (acc_addr),
    .stk  (acc_stack),
    .seg  (seg_q),
    .phys (phys_w),
    .bank (bank_w)
  );

  assign wr_ev    = acc_valid && acc_wr;
  assign rd_ev    = acc_valid && !acc_wr;
  assign seg_hit  = (bank_w == BK_CTL) && (phys_w[AW-1:0] == SEG_REG_ADR);
  assign sp_hit   = (bank_w == BK_CTL) && (phys_w[AW-1:0] == SP_REG_ADR);
  assign seg_ld_ev = wr_ev && seg_hit && !acc_stack;
  assign sp_ld_ev  = wr_ev && sp_hit;
  assign ram_bank  = (bank_w == BK_LOW) || (bank_w == BK_GREG) || (bank_w == BK_EXT);

  seg_xlate_regs #(.SP_INIT(SP_INIT), .SEG_INIT('0)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_seg (seg_ld_ev),
    .ld_sp  (sp_ld_ev),
    .wdata  (acc_wdata),
    .seg    (seg_q),
    .sp     (sp_q)
  );

  seg_xlate_rdmux #(.FILL(FILL)) u_rd (
    .bank (bank_w),
    .lo   (phys_w[AW-1:0]),
    .seg  (seg_q),
    .sp   (sp_q),
    .data (local_data)
  );

  assign phys_addr = phys_w;
  assign bank      = bank_w;
  assign ram_we    = wr_ev && ram_bank;
  assign local_rd  = rd_ev && !ram_bank;
endmodule

// File: rtl/seg_addr_xlate_chk.sv
module seg_addr_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_wr,
  input logic        acc_stack,
  input logic [7:0]  acc_addr,
  input logic [7:0]  acc_wdata,
  input logic [15:0] phys_addr,
  input logic [2:0]  bank,
  input logic        ram_we,
  input logic        local_rd,
  input logic [7:0]  local_data,
  input logic [7:0]  seg_q,
  input logic [7:0]  sp_q
);
  assert_upper_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr[7] |-> phys_addr == {8'h00, acc_addr});

  assert_lower_reloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_addr[7] && !acc_stack) |-> phys_addr[15:8] == seg_q);

  assert_stack_seg0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stack |-> phys_addr[15:8] == 8'h00);

  assert_stack_keeps_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr && acc_stack) |=> $stable(seg_q));

  assert_seg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr && !acc_stack && acc_addr == 8'hFF) |=> seg_q == $past(acc_wdata));

  assert_no_we_unbacked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == 3'd0 || bank == 3'd4) |-> !ram_we);

  assert_fill_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (local_rd && bank == 3'd0) |-> local_data == 8'hFF);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(seg_q) && $stable(sp_q)));

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!ram_we && !local_rd));
endmodule

bind seg_addr_xlate seg_addr_xlate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_wr     (acc_wr),
  .acc_stack  (acc_stack),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata),
  .phys_addr  (phys_addr),
  .bank       (bank),
  .ram_we     (ram_we),
  .local_rd   (local_rd),
  .local_data (local_data),
  .seg_q      (seg_q),
  .sp_q       (sp_q)
);

// File: tb/seg_addr_xlate_test.sv
module seg_addr_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_stack = 1'b0;
  logic [7:0]  acc_addr = 8'h00;
  logic [7:0]  acc_wdata = 8'h00;
  logic [15:0] phys_addr;
  logic [2:0]  bank;
  logic        ram_we;
  logic        local_rd;
  logic [7:0]  local_data;
  logic [7:0]  seg_q;
  logic [7:0]  sp_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int m_seg = 0;
  int m_sp = 'h6F;

  always #2 clk = ~clk;

  seg_addr_xlate uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, compare against model, then advance model.
  task automatic step(input bit v, input bit w, input bit s, input int a, input int d);
    int p, bk, e_data;
    bit e_we, e_rd;
    string ptag;
    @(negedge clk);
    acc_valid = v; acc_wr = w; acc_stack = s;
    acc_addr = 8'(a); acc_wdata = 8'(d);
    #1;
    if (a >= 128) begin p = a; ptag = "R1"; end
    else if (s) begin p = a % 128; ptag = "R3"; end
    else begin p = m_seg * 256 + a % 128; ptag = "R2"; end
    if (p < 'h70) bk = 1;
    else if (p == 'hFD || p == 'hFF) bk = 4;
    else if (p >= 'hF0 && p < 'h100) bk = 2;
    else if (p >= 'h100 && p < 'h180) bk = 3;
    else bk = 0;
    e_we = v && w && (bk >= 1 && bk <= 3);
    e_rd = v && !w && (bk == 0 || bk == 4);
    if (bk == 4) e_data = (p == 'hFF) ? m_seg : m_sp;
    else e_data = 'hFF;
    check(phys_addr == 16'(p), ptag, phys_addr, p);
    check(bank == 3'(bk), "R5", bank, bk);
    check(ram_we == e_we, "R9", ram_we, e_we);
    check(local_rd == e_rd, "R6", local_rd, e_rd);
    if (e_rd) check(local_data == 8'(e_data), (bk == 4) ? "R8" : "R6", local_data, e_data);
    check(seg_q == 8'(m_seg), "R7", seg_q, m_seg);
    check(sp_q == 8'(m_sp), "R8", sp_q, m_sp);
    if (v && w && a == 'hFF && !s) m_seg = d;
    if (v && w && a == 'hFD) m_sp = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(seg_q == 8'h00, "R4", seg_q, 0);
    check(sp_q == 8'h6F, "R4", sp_q, 'h6F);
    @(negedge clk) rst_n = 1'b1;
    check(seg_q == 8'h00, "R4", seg_q, 0);
    check(sp_q == 8'h6F, "R4", sp_q, 'h6F);
    // reads of control registers after reset (R8)
    step(1, 0, 0, 'hFF, 0);
    step(1, 0, 0, 'hFD, 0);
    // lower half with segment 0 (R2, R5)
    for (int a = 0; a < 128; a++) step(1, a % 2, 0, a, a);
    // set segment 0x37 and sweep upper half (R1, R7)
    step(1, 1, 0, 'hFF, 'h37);
    for (int a = 128; a < 256; a++) if (a != 'hFF && a != 'hFD) step(1, a % 3 == 0, a % 2, a, 'hC3);
    // unpopulated segment: fill reads and ignored writes (R6)
    for (int a = 0; a < 128; a += 5) step(1, a % 2, 0, a, 'h11);
    // stack bypass and stack write to 0xFF keeps segment (R3)
    for (int a = 0; a < 128; a += 3) step(1, a % 2, 1, a, 'h99);
    step(1, 1, 1, 'hFF, 'h05);
    step(1, 0, 0, 'hFF, 0);
    // back-to-back segment writes then extension bank (R7, R5)
    step(1, 1, 0, 'hFF, 'h02);
    step(1, 1, 0, 'hFF, 'h01);
    for (int a = 0; a < 128; a += 7) step(1, 1, 0, a, a);
    step(1, 0, 0, 'h10, 0);
    // stack pointer writes through both paths (R8)
    step(1, 1, 1, 'hFD, 'h40);
    step(1, 1, 0, 'hFD, 'h22);
    step(1, 0, 1, 'hFD, 0);
    // idle cycles with write-looking inputs (R9)
    step(0, 1, 0, 'hFF, 'hAA);
    step(0, 1, 0, 'hFD, 'hAA);
    step(0, 0, 0, 'h80, 0);
    // random stream
    for (int i = 0; i < 4000; i++) begin
      int a, r;
      r = $urandom_range(0, 9);
      if (r == 0) a = 'hFF;
      else if (r == 1) a = 'hFD;
      else a = $urandom_range(0, 255);
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           a, (r == 0) ? $urandom_range(0, 2) : $urandom_range(0, 255));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule